// File: doc/BRIEF.md
# Septenary-Weight Systolic MAC Array

This block is a grid of multiply-accumulate cells for low-precision neural network inference. Weights arrive packed three to a byte: one five-level weight drawn from {-2,-1,0,1,2} and two seven-level weights drawn from {-2,-1,-0.5,0,0.5,1,2}, about 2.67 bits per weight. Each byte is unpacked once, as it is loaded, into four control flags per weight: zero, negate, double and halve. A cell then multiplies its signed 8-bit activation by its weight using only a shift, an optional negation and an optional skip.

The grid has three rows and `COLS` columns, seven by default. Column `c` holds one packed byte, whose three digits give the weights of its three rows. Row `r` holds one activation, which is shared by every cell of that row. Weights and activations stay in place while the host pulses `mac_en` to accumulate. A `swap` pulse copies every live accumulator into its shadow copy and clears the live one. The shadow copies then leave one per cycle, through a chain that runs from cell to cell, while the live accumulators take new work.

Top module: `sevq_mac_array`

## Requirements
- R1: After reset, `res_valid` is 0 and `res_data` is 0. Every weight decodes as zero, every activation is 0, and every live and shadow accumulator is 0.
- R2: A byte value b below 245 holds three digits: d0 = b mod 5, d1 = (b div 5) mod 7 and d2 = b div 35. Row r of column c uses digit dr of that column's byte.
- R3: The five-level digit d0 maps codes 0, 1, 2, 3 and 4 to the weights 0, +1, +2, -1 and -2.
- R4: The seven-level digits d1 and d2 map codes 0 to 6 to the weights 0, +0.5, +1, +2, -0.5, -1 and -2.
- R5: Byte values 245 to 255 decode as zero for all three weights.
- R6: On a `mac_en` cycle, each cell adds or subtracts its addend, or leaves its sum unchanged when its weight is zero. The addend is the activation sign-extended to 9 bits, doubled for a weight of magnitude 2 and arithmetically shifted right by one for a weight of magnitude 0.5. A weight or activation load takes effect from the next cycle on, so a `mac_en` in the same cycle uses the old value.
- R7: Accumulators are 18-bit signed and wrap in two's complement on overflow.
- R8: A `swap` while `res_valid` is 0 moves each live sum into its shadow copy, including any `mac_en` contribution of that same cycle, and clears the live sum. From the next cycle `res_valid` is 1 for 3*COLS consecutive cycles. These cycles present cell k = r*COLS + c in increasing k order.
- R9: A `swap` while `res_valid` is 1 is ignored: the drain continues unchanged and the live sums are not cleared.
- R10: `res_data` is 0 in every cycle in which `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wt_we | input | 1 | Write the packed weight byte of one column |
| wt_col | input | $clog2(COLS) | Column index for the weight write |
| wt_byte | input | 8 | Packed byte holding three weights |
| act_we | input | 1 | Write the activation of one row |
| act_row | input | 2 | Row index for the activation write |
| act_val | input | 8 | Signed activation |
| mac_en | input | 1 | Accumulate one product in every cell |
| swap | input | 1 | Move live sums to the shadow copies and start the drain |
| res_valid | output | 1 | `res_data` carries a result |
| res_data | output | 18 | Drained signed sum |

## Verification
The bench builds the block with its default parameters: seven columns, 8-bit activations and 18-bit sums, 21 cells in all. With seven columns, a table of base bytes spread by a per-column stride reaches all five codes of d0 and all seven codes of d1 and d2. It also reaches extreme activations of -128 and 127, where a halving or doubling must keep the sign. With 18-bit sums, a run of 517 accumulations of +254 carries one cell past the positive limit, so the wrap can be observed in a short test.

// File: rtl/sevq_pkg.sv
// Package: shared weight-control type and the digit-to-control maps.
// Assumes the five-level digit is the least significant base-5 digit and
// the two seven-level digits follow it as base-7 digits.
package sevq_pkg;

    typedef struct packed {
        logic zero;   // weight is 0, skip the accumulate
        logic neg;    // subtract instead of add
        logic dbl;    // magnitude 2
        logic hlv;    // magnitude 0.5
    } wctl_t;

    localparam int unsigned DIGITS    = 3;
    localparam int unsigned CODE_SPAN = 245;  // 5 * 7 * 7 valid byte values

    function automatic wctl_t mk_ctl(input logic z, input logic n,
                                     input logic d, input logic h);
        wctl_t t;
        t.zero = z;
        t.neg  = n;
        t.dbl  = d;
        t.hlv  = h;
        return t;
    endfunction

    // Five-level code to controls: 0,+1,+2,-1,-2
    function automatic wctl_t five_ctl(input logic [2:0] d);
        case (d)
            3'd1:    return mk_ctl(1'b0, 1'b0, 1'b0, 1'b0);
            3'd2:    return mk_ctl(1'b0, 1'b0, 1'b1, 1'b0);
            3'd3:    return mk_ctl(1'b0, 1'b1, 1'b0, 1'b0);
            3'd4:    return mk_ctl(1'b0, 1'b1, 1'b1, 1'b0);
            default: return mk_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        endcase
    endfunction

    // Seven-level code to controls: 0,+0.5,+1,+2,-0.5,-1,-2
    function automatic wctl_t seven_ctl(input logic [2:0] d);
        case (d)
            3'd1:    return mk_ctl(1'b0, 1'b0, 1'b0, 1'b1);
            3'd2:    return mk_ctl(1'b0, 1'b0, 1'b0, 1'b0);
            3'd3:    return mk_ctl(1'b0, 1'b0, 1'b1, 1'b0);
            3'd4:    return mk_ctl(1'b0, 1'b1, 1'b0, 1'b1);
            3'd5:    return mk_ctl(1'b0, 1'b1, 1'b0, 1'b0);
            3'd6:    return mk_ctl(1'b0, 1'b1, 1'b1, 1'b0);
            default: return mk_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        endcase
    endfunction

endpackage

// File: rtl/sevq_unpack.sv
// Unpacker: splits one packed byte into three digits and maps each digit to
// weight controls. Purely combinational. Assumes byte values from 245 up are
// unused and turns them into three zero weights.
module sevq_unpack
    import sevq_pkg::*;
(
    input  logic [7:0]               pk_byte,
    output wctl_t [DIGITS-1:0]       ctl
);
    logic [2:0] dig0, dig1, dig2;
    logic       in_range;

    // Digit extraction by constant division
    always_comb begin
        dig0     = 3'(pk_byte % 8'd5);
        dig1     = 3'((pk_byte / 8'd5) % 8'd7);
        dig2     = 3'(pk_byte / 8'd35);
        in_range = (pk_byte < 8'(CODE_SPAN));
    end

    // Map digits to controls, forcing zero weights for unused codes
    always_comb begin
        ctl[0] = five_ctl(in_range ? dig0 : 3'd0);
        ctl[1] = seven_ctl(in_range ? dig1 : 3'd0);
        ctl[2] = seven_ctl(in_range ? dig2 : 3'd0);
    end
endmodule

// File: rtl/sevq_cell.sv
// Cell: one live accumulator with a shadow copy that is also a stage of the
// result chain. Assumes swap_go and shift_en are never both set.
module sevq_cell
    import sevq_pkg::*;
#(
    parameter int unsigned ACT_W = 8,
    parameter int unsigned ACC_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wctl_t            ctl,
    input  logic [ACT_W-1:0] act,
    input  logic             mac_en,
    input  logic             swap_go,
    input  logic             shift_en,
    input  logic [ACC_W-1:0] chain_in,
    output logic [ACC_W-1:0] chain_out
);
    localparam int unsigned EXT_W = ACT_W + 1;
    localparam int unsigned PAD_W = ACC_W - EXT_W;

    logic signed [EXT_W-1:0] a_ext, addend;
    logic        [ACC_W-1:0] add_wide, live, live_nxt, shadow;

    // Addend: sign-extend, then double, halve or pass
    always_comb begin
        a_ext  = $signed({act[ACT_W-1], act});
        if (ctl.dbl)      addend = a_ext <<< 1;
        else if (ctl.hlv) addend = a_ext >>> 1;
        else              addend = a_ext;
        add_wide = {{PAD_W{addend[EXT_W-1]}}, addend};
    end

    // Next live sum: skip, subtract or add, wrapping at ACC_W bits
    always_comb begin
        live_nxt = live;
        if (mac_en && !ctl.zero)
            live_nxt = ctl.neg ? (live - add_wide) : (live + add_wide);
    end

    // Live and shadow registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live   <= '0;
            shadow <= '0;
        end else if (swap_go) begin
            shadow <= live_nxt;
            live   <= '0;
        end else begin
            live <= live_nxt;
            if (shift_en) shadow <= chain_in;
        end
    end

    assign chain_out = shadow;
endmodule

// File: rtl/sevq_mac_array.sv
// Top: three rows by COLS columns of cells. Holds the decoded weights of one
// packed byte per column and one activation per row, and drains the shadow
// copies through a chain that runs from the last cell to cell 0.
// Assumes the row count equals the three digits of a packed byte.
module sevq_mac_array
    import sevq_pkg::*;
#(
    parameter int unsigned COLS  = 7,
    parameter int unsigned ACT_W = 8,
    parameter int unsigned ACC_W = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wt_we,
    input  logic [$clog2(COLS)-1:0]   wt_col,
    input  logic [7:0]                wt_byte,
    input  logic                      act_we,
    input  logic [1:0]                act_row,
    input  logic [ACT_W-1:0]          act_val,
    input  logic                      mac_en,
    input  logic                      swap,
    output logic                      res_valid,
    output logic [ACC_W-1:0]          res_data
);
    localparam int unsigned ROWS  = DIGITS;
    localparam int unsigned CELLS = ROWS * COLS;
    localparam int unsigned CNT_W = $clog2(CELLS + 1);

    wctl_t [ROWS-1:0]  wreg [COLS];
    wctl_t [ROWS-1:0]  dec;
    logic [ACT_W-1:0]  areg [ROWS];
    logic [ACC_W-1:0]  chain [CELLS+1];
    logic [CNT_W-1:0]  drain_cnt;
    logic              swap_go, shift_en;

    sevq_unpack u_unpack (
        .pk_byte (wt_byte),
        .ctl     (dec)
    );

    // Weight store: decoded controls per column
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < COLS; c++)
                for (int r = 0; r < ROWS; r++)
                    wreg[c][r] <= mk_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        end else if (wt_we && (int'(wt_col) < COLS)) begin
            wreg[wt_col] <= dec;
        end
    end

    // Activation store: one signed value per row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) areg[r] <= '0;
        end else if (act_we && (int'(act_row) < ROWS)) begin
            areg[act_row] <= act_val;
        end
    end

    // Drain control: a swap is accepted only while idle
    always_comb begin
        swap_go  = swap && (drain_cnt == '0);
        shift_en = (drain_cnt != '0);
    end

    // Drain counter: loaded on an accepted swap, counts results out
    always_ff @(posedge clk) begin
        if (!rst_n)        drain_cnt <= '0;
        else if (swap_go)  drain_cnt <= CNT_W'(CELLS);
        else if (shift_en) drain_cnt <= drain_cnt - 1'b1;
    end

    assign chain[CELLS] = '0;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int unsigned K = r * COLS + c;
            sevq_cell #(
                .ACT_W (ACT_W),
                .ACC_W (ACC_W)
            ) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .ctl       (wreg[c][r]),
                .act       (areg[r]),
                .mac_en    (mac_en),
                .swap_go   (swap_go),
                .shift_en  (shift_en),
                .chain_in  (chain[K+1]),
                .chain_out (chain[K])
            );
        end
    end

    assign res_valid = shift_en;
    assign res_data  = chain[0];
endmodule

// File: rtl/sevq_mac_array_chk.sv
// Checker: protocol properties of the result port, bound to the top module.
// Counts the length of each valid burst itself instead of looking back.
module sevq_mac_array_chk #(
    parameter int unsigned CELLS = 21,
    parameter int unsigned ACC_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             swap,
    input logic             res_valid,
    input logic [ACC_W-1:0] res_data
);
    localparam int unsigned VC_W = $clog2(CELLS + 1);
    logic [VC_W-1:0] vcnt;

    // Valid cycles seen so far in the current burst
    always_ff @(posedge clk) begin
        if (!rst_n)         vcnt <= '0;
        else if (res_valid) vcnt <= vcnt + 1'b1;
        else                vcnt <= '0;
    end

    a_r8_swap_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !res_valid) |=> res_valid);

    a_r8_burst_max: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (int'(vcnt) < CELLS));

    a_r8_burst_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(res_valid) |-> (int'($past(vcnt)) == CELLS - 1));

    a_r9_drain_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (int'(vcnt) < CELLS - 1)) |=> res_valid);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_data == '0));
endmodule

bind sevq_mac_array sevq_mac_array_chk #(
    .CELLS (3 * COLS),
    .ACC_W (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap      (swap),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/sim_sevq_mac_array.sv
module sim_sevq_mac_array;
    localparam int COLS  = 7;
    localparam int ROWS  = 3;
    localparam int CELLS = ROWS * COLS;

    // Vector table: {base byte, act row0, act row1, act row2}
    localparam logic [31:0] VEC [8] = '{
        {8'd0,   8'd10,  8'd20,  8'd30},
        {8'd17,  8'h80,  8'd7,   8'hF3},
        {8'd101, 8'd127, 8'h81,  8'd5},
        {8'd244, 8'hFF,  8'd1,   8'd127},
        {8'd63,  8'd3,   8'h80,  8'hFE},
        {8'd200, 8'd99,  8'd45,  8'h9C},
        {8'd35,  8'h85,  8'd127, 8'd1},
        {8'd150, 8'd64,  8'hC0,  8'd33}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wt_we = 1'b0, act_we = 1'b0, mac_en = 1'b0, swap = 1'b0;
    logic [2:0]  wt_col = '0;
    logic [7:0]  wt_byte = '0, act_val = '0;
    logic [1:0]  act_row = '0;
    logic        res_valid;
    logic [17:0] res_data;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] m_w [COLS];
    int         m_a [ROWS];
    int         m_live [CELLS];
    int         m_sh [CELLS];

    always #5 clk = ~clk;

    sevq_mac_array u0 (
        .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_col(wt_col),
        .wt_byte(wt_byte), .act_we(act_we), .act_row(act_row),
        .act_val(act_val), .mac_en(mac_en), .swap(swap),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(string req, logic [17:0] got, logic [17:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Weight in half units from the requirements (R2..R5)
    function automatic int half_w(logic [7:0] b, int r);
        int d;
        if (b > 8'd244) return 0;
        if (r == 0) begin
            d = b % 5;
            case (d) 1: return 2; 2: return 4; 3: return -2; 4: return -4; default: return 0; endcase
        end
        d = (r == 1) ? (b / 5) % 7 : b / 35;
        case (d)
            1: return 1; 2: return 2; 3: return 4;
            4: return -1; 5: return -2; 6: return -4;
            default: return 0;
        endcase
    endfunction

    // Cell term per R6: magnitude by shift, then sign
    function automatic int term(int hw, int a);
        int m;
        int mag = (hw < 0) ? -hw : hw;
        case (mag) 1: m = a >>> 1; 2: m = a; 4: m = a * 2; default: m = 0; endcase
        return (hw < 0) ? -m : m;
    endfunction

    function automatic void model_mac();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                m_live[r*COLS+c] += term(half_w(m_w[c], r), m_a[r]);
    endfunction

    function automatic void model_swap();
        for (int k = 0; k < CELLS; k++) begin
            m_sh[k] = m_live[k];
            m_live[k] = 0;
        end
    endfunction

    task automatic set_w(int c, logic [7:0] b);
        @(negedge clk); wt_we = 1; wt_col = 3'(c); wt_byte = b;
        @(posedge clk); #1 wt_we = 0;
        m_w[c] = b;
    endtask

    task automatic set_a(int r, logic [7:0] v);
        @(negedge clk); act_we = 1; act_row = 2'(r); act_val = v;
        @(posedge clk); #1 act_we = 0;
        m_a[r] = int'($signed(v));
    endtask

    task automatic mac_n(int n);
        for (int i = 0; i < n; i++) model_mac();
        @(negedge clk); mac_en = 1;
        repeat (n) @(posedge clk);
        #1 mac_en = 0;
    endtask

    task automatic do_swap(bit with_mac);
        if (with_mac) model_mac();
        model_swap();
        @(negedge clk); swap = 1; mac_en = with_mac;
        @(posedge clk); #1 swap = 0; mac_en = 0;
    endtask

    // Collect a full burst; optionally inject swap+mac at index inj (R9)
    task automatic drain(string req, int inj);
        for (int k = 0; k < CELLS; k++) begin
            @(negedge clk);
            swap = 0; mac_en = 0;
            check({req, " valid"}, 18'(res_valid), 18'd1);
            check(req, res_data, 18'(m_sh[k]));
            if (k == inj) begin
                swap = 1; mac_en = 1;
                model_mac();
            end
        end
        @(negedge clk);
        swap = 0; mac_en = 0;
        check({req, " end valid"}, 18'(res_valid), 18'd0);
        check("R10 idle data", res_data, 18'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < COLS; c++) m_w[c] = 8'd0;
        for (int r = 0; r < ROWS; r++) m_a[r] = 0;
        for (int k = 0; k < CELLS; k++) begin m_live[k] = 0; m_sh[k] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state at the ports
        @(negedge clk);
        check("R1 valid", 18'(res_valid), 18'd0);
        check("R1 data", res_data, 18'd0);
        // R1: zero weights after reset, so nonzero activations add nothing
        for (int r = 0; r < ROWS; r++) set_a(r, 8'd50);
        mac_n(3);
        do_swap(0);
        drain("R1 zero accumulators", -1);

        // R2 R3 R4 R6: table walk, drained after every fourth vector
        for (int v = 0; v < 8; v++) begin
            for (int c = 0; c < COLS; c++)
                set_w(c, 8'((int'(VEC[v][31:24]) + 37 * c) % 245));
            set_a(0, VEC[v][23:16]);
            set_a(1, VEC[v][15:8]);
            set_a(2, VEC[v][7:0]);
            mac_n(1 + v % 2);
            if (v % 4 == 3) begin
                do_swap(0);
                drain("R2 R3 R4 R6 table", -1);
            end
        end

        // R5: unused codes 245..255 give three zero weights
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < COLS; c++) set_w(c, 8'(245 + (p * COLS + c) % 11));
            for (int r = 0; r < ROWS; r++) set_a(r, 8'h81);
            mac_n(2);
            do_swap(0);
            drain("R5 unused codes", -1);
        end

        // R6: weight load and mac in the same cycle use the old weight
        set_w(0, 8'd1);
        set_a(0, 8'd10);
        model_mac();
        @(negedge clk); wt_we = 1; wt_col = 3'd0; wt_byte = 8'd2; mac_en = 1;
        @(posedge clk); #1 wt_we = 0; mac_en = 0;
        m_w[0] = 8'd2;
        mac_n(1);
        do_swap(0);
        drain("R6 load timing", -1);

        // R7: wrap past the positive limit with +2 * 127 per step
        for (int c = 0; c < COLS; c++) set_w(c, 8'd2);
        set_a(0, 8'd127);
        set_a(1, 8'h80);
        mac_n(517);
        do_swap(0);
        drain("R7 wrap", -1);

        // R8: swap with mac in the same cycle includes it and clears live
        set_a(2, 8'hF0);
        for (int c = 0; c < COLS; c++) set_w(c, 8'(c * 36 + 3));
        mac_n(2);
        do_swap(1);
        drain("R8 swap with mac", -1);
        do_swap(0);
        drain("R8 live cleared", -1);

        // R9: swap during a drain is ignored and live is kept
        mac_n(1);
        do_swap(0);
        drain("R9 drain unchanged", 5);
        do_swap(0);
        drain("R9 live kept", -1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule